// File: doc/BRIEF.md
# Packed Command Queue Executor

This engine takes 128-bit words from an upstream fetch stage. Each word holds two 64-bit commands. The engine runs the lower command first and the upper command second. Every command is one of five kinds: it does nothing, it makes a masked register write, it stalls on one line of a trigger vector, or it polls a register until a masked comparison succeeds or until it fails.

Register access goes through a simple bus master. The engine asserts a one-cycle read request, waits for read data to return with a valid strobe, and then issues a one-cycle write. A write command is carried out as read, merge, write back.

A timeout input lets an outside timer abandon a stalled wait or poll. When that happens, a sticky error flag is set and execution carries on with the next command. The engine accepts a new word only after both halves of the current word have completed.

Top module: `cmdq_engine`

## Requirements
- R1: After reset the engine is idle. `busy`=0, `wordReady`=1 and `errFlag`=0, and no read request or write strobe is driven while idle.
- R2: The command in bits [63:0] of a word completes before the command in bits [127:64] begins. Their bus accesses appear in that order.
- R3: The operation code sits in command bits [63:56]. 0x57 selects write, 0x70 selects poll-equal, 0x43 selects poll-not-equal and 0x46 selects wait. Every other code is a null command, which performs no bus access and completes.
- R4: A write command uses register address [55:32], mask [31:16] and value [15:0]. The engine reads the register and writes back `(old & mask) | (value & ~mask)`. `regWrMask` carries `~mask`, so a mask bit of 1 keeps the old bit.
- R5: A wait command whose value bit 15 is 0 stalls until `trigBus[value[3:0]]` is 1. The other trigger lines have no effect.
- R6: A wait command whose value bit 15 is 1 stalls until the selected trigger line is seen to fall from 1 to 0 between two consecutive cycles. A line that stays high does not release it.
- R7: Poll-equal reads the register again and again until `((data ^ value) & ~mask) == 0`. Mask bits set to 1 are excluded from the comparison.
- R8: Poll-not-equal reads the register again and again until `((data ^ value) & ~mask) != 0`.
- R9: If `timeout` is high on a clock edge while a wait awaits its trigger, or while a poll awaits read data, that command is abandoned and execution continues with the next command. The timeout takes priority over a trigger or a match arriving on the same edge. `errFlag` then becomes 1 and stays 1 until reset.
- R10: A word is accepted only on an edge where `wordValid` and `wordReady` are both high. `wordReady` stays low, and `busy` stays high, from acceptance until both halves are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Command word offered |
| wordData | input | 128 | Two packed commands, lower half runs first |
| wordReady | output | 1 | Engine can take a word |
| busy | output | 1 | A word is being executed |
| errFlag | output | 1 | Sticky: a wait or poll was abandoned by timeout |
| regAddr | output | ADDR_W | Register address of the current command |
| regRdReq | output | 1 | One-cycle register read request |
| regRdValid | input | 1 | Read data valid |
| regRdData | input | 16 | Read data |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 16 | Merged write data |
| regWrMask | output | 16 | Bits changed by the write (1 = changed) |
| trigBus | input | TRIG_W | Trigger lines for wait commands |
| timeout | input | 1 | Abandon the current wait or poll |

## Verification
The hardest states to reach from the ports are the long stalls: a poll that keeps re-reading and a wait whose trigger never comes. The timeout has to land while the engine is actually waiting, and not during the single decode cycle between two polls.

The bench models the register file itself. It holds a polled register at a non-matching value for many read rounds, confirms the engine is still busy, and only then changes the value. For the timeout case, the pulse is held across two edges so that one of them always falls in a waiting state. The bench then confirms that the upper-half command still ran.

Trigger indices are swept while all other lines are held high. The falling mode is checked against a line that stays high for a long time before it drops.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int WORD_W = 128;
  localparam int CMD_W  = 64;
  localparam int VAL_W  = 16;

  localparam logic [7:0] OP_WRITE  = 8'h57;
  localparam logic [7:0] OP_POLLEQ = 8'h70;
  localparam logic [7:0] OP_POLLNE = 8'h43;
  localparam logic [7:0] OP_WAIT   = 8'h46;

  typedef enum logic [2:0] {
    KIND_NULL, KIND_WRITE, KIND_POLLEQ, KIND_POLLNE, KIND_WAIT
  } cmdKind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_RDWAIT, ST_WRITE, ST_TRIG, ST_ADV
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic nextHalf;
    logic captureRd;
    logic raiseErr;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    cmdKind_e kind;
    logic     lastHalf;
    logic     pollHit;
    logic     trigHit;
  } dpStatus_t;
endpackage

// File: rtl/cmdq_dp.sv
module cmdq_dp
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TRIG_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [WORD_W-1:0]   wordData,
  input  logic [VAL_W-1:0]    regRdData,
  input  logic [TRIG_W-1:0]   trigBus,
  output dpStatus_t           status,
  output logic [ADDR_W-1:0]   regAddr,
  output logic [VAL_W-1:0]    regWrData,
  output logic [VAL_W-1:0]    regWrMask,
  output logic                errFlag
);
  localparam int IDX_W = (TRIG_W > 1) ? $clog2(TRIG_W) : 1;

  logic [WORD_W-1:0] wordQ;
  logic              halfQ;
  logic [VAL_W-1:0]  rdQ;
  logic [TRIG_W-1:0] trigPrev;
  logic              errQ;

  logic [CMD_W-1:0]  cmd;
  logic [7:0]        opcode;
  logic [VAL_W-1:0]  mask;
  logic [VAL_W-1:0]  value;
  logic [IDX_W-1:0]  trigIdx;
  logic              fallMode;
  logic              lineNow;
  logic              linePrev;
  logic              pollDiff;
  cmdKind_e          kind;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ    <= '0;
      halfQ    <= 1'b0;
      rdQ      <= '0;
      trigPrev <= '0;
      errQ     <= 1'b0;
    end else begin
      trigPrev <= trigBus;
      if (strobe.loadWord) begin
        wordQ <= wordData;
        halfQ <= 1'b0;
      end else if (strobe.nextHalf) begin
        halfQ <= 1'b1;
      end
      if (strobe.captureRd) rdQ  <= regRdData;
      if (strobe.raiseErr)  errQ <= 1'b1;
    end
  end

  assign cmd      = halfQ ? wordQ[WORD_W-1:CMD_W] : wordQ[CMD_W-1:0];
  assign opcode   = cmd[63:56];
  assign regAddr  = cmd[32 +: ADDR_W];
  assign mask     = cmd[31:16];
  assign value    = cmd[15:0];
  assign trigIdx  = value[IDX_W-1:0];
  assign fallMode = value[15];

  always_comb begin
    unique case (opcode)
      OP_WRITE:  kind = KIND_WRITE;
      OP_POLLEQ: kind = KIND_POLLEQ;
      OP_POLLNE: kind = KIND_POLLNE;
      OP_WAIT:   kind = KIND_WAIT;
      default:   kind = KIND_NULL;
    endcase
  end

  assign lineNow  = trigBus[trigIdx];
  assign linePrev = trigPrev[trigIdx];
  assign pollDiff = |((regRdData ^ value) & ~mask);

  assign status.kind     = kind;
  assign status.lastHalf = halfQ;
  assign status.pollHit  = (kind == KIND_POLLNE) ? pollDiff : !pollDiff;
  assign status.trigHit  = fallMode ? (linePrev & ~lineNow) : lineNow;

  assign regWrData = (rdQ & mask) | (value & ~mask);
  assign regWrMask = ~mask;
  assign errFlag   = errQ;
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  input  logic        regRdValid,
  input  logic        timeout,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        wordReady,
  output logic        busy,
  output logic        regRdReq,
  output logic        regWrEn
);
  state_e stateQ, stateD;
  logic   isPoll;

  assign isPoll = (status.kind == KIND_POLLEQ) || (status.kind == KIND_POLLNE);

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD    = stateQ;
    strobe    = '0;
    wordReady = 1'b0;
    regRdReq  = 1'b0;
    regWrEn   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        wordReady = 1'b1;
        if (wordValid) begin
          strobe.loadWord = 1'b1;
          stateD = ST_EXEC;
        end
      end
      ST_EXEC: begin
        unique case (status.kind)
          KIND_NULL: stateD = ST_ADV;
          KIND_WAIT: stateD = ST_TRIG;
          default: begin
            regRdReq = 1'b1;
            stateD = ST_RDWAIT;
          end
        endcase
      end
      ST_RDWAIT: begin
        if (isPoll && timeout) begin
          strobe.raiseErr = 1'b1;
          stateD = ST_ADV;
        end else if (regRdValid) begin
          if (!isPoll) begin
            strobe.captureRd = 1'b1;
            stateD = ST_WRITE;
          end else if (status.pollHit) begin
            stateD = ST_ADV;
          end else begin
            stateD = ST_EXEC;
          end
        end
      end
      ST_WRITE: begin
        regWrEn = 1'b1;
        stateD = ST_ADV;
      end
      ST_TRIG: begin
        if (timeout) begin
          strobe.raiseErr = 1'b1;
          stateD = ST_ADV;
        end else if (status.trigHit) begin
          stateD = ST_ADV;
        end
      end
      ST_ADV: begin
        if (status.lastHalf) begin
          stateD = ST_IDLE;
        end else begin
          strobe.nextHalf = 1'b1;
          stateD = ST_EXEC;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TRIG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [127:0]      wordData,
  output logic              wordReady,
  output logic              busy,
  output logic              errFlag,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regRdReq,
  input  logic              regRdValid,
  input  logic [15:0]       regRdData,
  output logic              regWrEn,
  output logic [15:0]       regWrData,
  output logic [15:0]       regWrMask,
  input  logic [TRIG_W-1:0] trigBus,
  input  logic              timeout
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  cmdq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .regRdValid(regRdValid),
    .timeout(timeout), .status(status), .strobe(strobe), .wordReady(wordReady),
    .busy(busy), .regRdReq(regRdReq), .regWrEn(regWrEn)
  );

  cmdq_dp #(.ADDR_W(ADDR_W), .TRIG_W(TRIG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordData(wordData),
    .regRdData(regRdData), .trigBus(trigBus), .status(status),
    .regAddr(regAddr), .regWrData(regWrData), .regWrMask(regWrMask),
    .errFlag(errFlag)
  );
endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
  parameter int ADDR_W = 24,
  parameter int TRIG_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordValid,
  input logic [127:0]      wordData,
  input logic              wordReady,
  input logic              busy,
  input logic              errFlag,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRdReq,
  input logic              regRdValid,
  input logic [15:0]       regRdData,
  input logic              regWrEn,
  input logic [15:0]       regWrData,
  input logic [15:0]       regWrMask,
  input logic [TRIG_W-1:0] trigBus,
  input logic              timeout
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!regWrEn && !regRdReq)); // R1
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(regRdValid)); // R4
  AST_NO_RD_WR_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdReq)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(timeout)); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady) |=> (busy && !wordReady)); // R10
endmodule

bind cmdq_engine cmdq_engine_chk #(.ADDR_W(ADDR_W), .TRIG_W(TRIG_W)) u_chk (.*);

// File: tb/cmdq_engine_bench.sv
module cmdq_engine_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic [127:0] wordData = '0;
  logic wordReady, busy, errFlag, regRdReq, regWrEn;
  logic [23:0] regAddr;
  logic regRdValid = 1'b0;
  logic [15:0] regRdData = '0;
  logic [15:0] regWrData, regWrMask;
  logic [15:0] trigBus = '0;
  logic timeout = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [15:0] regs [4];
  int wrCount = 0;
  int rdCount = 0;
  logic [23:0] wrLog [2];
  logic [15:0] lastMask;

  always #2 clk = ~clk;

  cmdq_engine u_cmdq_engine (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .wordReady(wordReady), .busy(busy), .errFlag(errFlag), .regAddr(regAddr),
    .regRdReq(regRdReq), .regRdValid(regRdValid), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrData(regWrData), .regWrMask(regWrMask),
    .trigBus(trigBus), .timeout(timeout)
  );

  // register file model: read data returns one cycle after the request
  always @(posedge clk) begin
    regRdValid <= regRdReq;
    regRdData  <= regs[regAddr[1:0]];
    if (regRdReq) rdCount <= rdCount + 1;
    if (regWrEn) begin
      regs[regAddr[1:0]] <= regWrData;
      lastMask <= regWrMask;
      if (wrCount < 2) wrLog[wrCount] <= regAddr;
      wrCount <= wrCount + 1;
    end
  end

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [23:0] a,
                                     input logic [15:0] m, input logic [15:0] v);
    return {op, a, m, v};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic sendWord(input logic [127:0] w);
    @(negedge clk);
    while (!wordReady) @(negedge clk);
    wordValid = 1'b1;
    wordData  = w;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (busy && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  localparam logic [63:0] NOP = 64'h0;

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finishRun();
  end

  initial begin
    int cyc;
    logic [15:0] old, m, v, expv;
    for (int i = 0; i < 4; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!busy && wordReady && !errFlag && !regWrEn && !regRdReq, "R1 reset",
          {busy, wordReady, errFlag, regWrEn, regRdReq}, 5'b01000);

    // R4 masked write sweep
    for (int i = 0; i < 16; i++) begin
      old = 16'hA5C3 ^ (16'(i) * 16'h1111);
      m   = (16'hFFFF >> i) ^ (16'(i) * 16'h0101);
      v   = ~old + 16'(i);
      expv = (old & m) | (v & ~m);
      regs[0] = old;
      sendWord({NOP, mk(8'h57, 24'h0, m, v)});
      waitIdle(cyc);
      check(regs[0] == expv, "R4 merge", regs[0], expv);
      check(lastMask == ~m, "R4 mask", lastMask, ~m);
    end

    // R2 ordering within a word
    wrCount = 0;
    sendWord({mk(8'h57, 24'h100001, 16'hFF00, 16'hABCD),
              mk(8'h57, 24'h000001, 16'h0000, 16'h1234)});
    waitIdle(cyc);
    check(regs[1] == 16'h12CD, "R2 final value", regs[1], 16'h12CD);
    check(wrLog[0] == 24'h000001 && wrLog[1] == 24'h100001, "R2 order",
          {wrLog[0][23:20], wrLog[1][23:20]}, 8'h01);

    // R3 every non-command opcode is null
    wrCount = 0;
    rdCount = 0;
    for (int op = 0; op < 256; op++) begin
      if (op != 8'h57 && op != 8'h70 && op != 8'h43 && op != 8'h46)
        sendWord({mk(8'(op), 24'h2, 16'h0, 16'hFFFF), mk(8'(op), 24'h3, 16'h0, 16'h1)});
    end
    waitIdle(cyc);
    check(wrCount == 0 && rdCount == 0 && !busy, "R3 null", wrCount + rdCount, 0);

    // R5 level wait, all indices, other lines high
    for (int idx = 0; idx < 16; idx++) begin
      trigBus = ~(16'h1 << idx);
      sendWord({NOP, mk(8'h46, 24'h0, 16'h0, 16'(idx))});
      repeat (8) @(negedge clk);
      check(busy, "R5 stall", busy, 1);
      check(!wordReady, "R10 not ready", wordReady, 0);
      trigBus = 16'h1 << idx;
      waitIdle(cyc);
      check(!busy && cyc < 6, "R5 release", cyc, 3);
      trigBus = '0;
    end

    // R6 falling-edge wait
    trigBus = 16'h0020;
    repeat (2) @(negedge clk);
    sendWord({NOP, mk(8'h46, 24'h0, 16'h0, 16'h8005)});
    repeat (10) @(negedge clk);
    check(busy, "R6 high line holds", busy, 1);
    trigBus = 16'h0000;
    waitIdle(cyc);
    check(!busy && cyc < 6, "R6 fall releases", cyc, 3);

    // R7 poll-equal: only low byte compared
    regs[2] = 16'h0000;
    sendWord({NOP, mk(8'h70, 24'h2, 16'hFF00, 16'h77A5)});
    repeat (20) @(negedge clk);
    check(busy, "R7 keeps polling", busy, 1);
    regs[2] = 16'h12A5;
    waitIdle(cyc);
    check(!busy && !errFlag, "R7 match", {busy, errFlag}, 0);

    // R8 poll-not-equal: difference only in masked bit does not count
    regs[3] = 16'h5555;
    sendWord({NOP, mk(8'h43, 24'h3, 16'h8000, 16'hD555)});
    repeat (20) @(negedge clk);
    check(busy, "R8 keeps polling", busy, 1);
    regs[3] = 16'h5554;
    waitIdle(cyc);
    check(!busy && !errFlag, "R8 differ", {busy, errFlag}, 0);

    // R9 timeout on poll, next half still runs
    regs[2] = 16'h0000;
    regs[0] = 16'h0000;
    sendWord({mk(8'h57, 24'h0, 16'h0000, 16'hBEEF), mk(8'h70, 24'h2, 16'h0000, 16'h0001)});
    repeat (10) @(negedge clk);
    check(busy && !errFlag, "R9 before timeout", {busy, errFlag}, 2'b10);
    timeout = 1'b1;
    repeat (2) @(negedge clk);
    timeout = 1'b0;
    waitIdle(cyc);
    check(errFlag, "R9 flag", errFlag, 1);
    check(regs[0] == 16'hBEEF, "R9 next command", regs[0], 16'hBEEF);

    // R9 timeout on wait, flag stays set
    trigBus = '0;
    sendWord({NOP, mk(8'h46, 24'h0, 16'h0, 16'h0003)});
    repeat (5) @(negedge clk);
    timeout = 1'b1;
    @(negedge clk);
    timeout = 1'b0;
    waitIdle(cyc);
    check(!busy && errFlag, "R9 wait abandon", {busy, errFlag}, 2'b01);
    sendWord({NOP, NOP});
    waitIdle(cyc);
    check(errFlag && wordReady, "R9 sticky", {errFlag, wordReady}, 2'b11);

    finishRun();
  end
endmodule